// File: doc/BRIEF.md
# Blocked Gram Matrix Accumulator

This block reads a tall matrix of signed fixed-point samples as a stream, one sample row of NF feature values per accepted beat. In one pass over the data it builds two results. The first is the NF x NF matrix formed by multiplying the transposed matrix with itself. The second is the sum of each feature column. A later stage derives a standardized covariance from these: the column sums give the means, and each covariance entry comes from the product term, the means and the sample count. That stage divides, takes square roots and normalizes. This block does none of those.

Incoming rows are collected into a tile of NF rows. Each tile is then folded into a running accumulator, one upper-triangle element per cycle, using a single NF-wide signed dot product. The cost of the datapath is set by NF, not by the number of samples. The input is held off while a tile is being folded. If the stream ends part-way through a tile, the unfilled rows count as zero.

A start pulse opens a new matrix. The done output pulses when the final tile has been folded. Results are then read back by row and column index. The lower triangle is served from its mirror element.

Top module: `gram_accum`

## Requirements
- R1: A `start` pulse discards all earlier work. In the cycle after it, `s_ready` is high and `done` is low. The results finally reported cover only the rows accepted since the most recent start.
- R2: After completion, the readout of element (r,c) equals the sum over all accepted rows k of A[k][r]*A[k][c]. Feature f of a row is carried in `s_data[f*DW +: DW]` as a two's-complement value.
- R3: Column sums are formed in the same pass as the products. After completion, `rd_sum` equals the signed sum of feature column `rd_col` over all accepted rows.
- R4: Rows are absorbed in tiles of NF. After the edge that accepts the NF-th row of a tile that is not the last, `s_ready` stays low for exactly NF*(NF+1)/2 cycles and then returns high.
- R5: A stream whose `s_last` row does not complete a tile is padded with zero rows. The padding changes neither products nor sums, and the final fold still takes NF*(NF+1)/2 cycles.
- R6: `done` is high for exactly one cycle. It rises at the NF*(NF+1)/2-th clock edge after the edge that accepts the row marked `s_last`.
- R7: `rd_gram` and `rd_sum` are registered. They show the values for the `rd_row`/`rd_col` sampled at the previous edge. For rd_row > rd_col, `rd_gram` returns the element (rd_col, rd_row).
- R8: `s_ready` is low from reset until the first start, and from `done` until the next start. Rows offered in those periods, including ones marked `s_last`, have no effect on any result.
- R9: Accumulators do not overflow for up to NS_MAX rows of arbitrary inputs, full-scale values included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new matrix; discards previous results |
| s_valid | input | 1 | A sample row is offered |
| s_ready | output | 1 | The block can accept a row this cycle |
| s_data | input | NF*DW | Sample row; feature f in bits [f*DW +: DW] |
| s_last | input | 1 | Marks the final row of the matrix |
| done | output | 1 | One-cycle pulse when all results are final |
| rd_row | input | RW | Readout row index |
| rd_col | input | RW | Readout column index; also selects the column sum |
| rd_gram | output | AW | Signed accumulated product element, one-cycle latency |
| rd_sum | output | SW | Signed column sum for rd_col, one-cycle latency |

## Verification
The embedded properties watch several rules on every cycle. Accepting the row that closes a tile must drop `s_ready`. A start must reopen the input with `done` low. `done` must never last two cycles, and `s_ready` must stay low while it is high. Column sums may change only when a row is accepted. A clear of the tile store must leave zeros in the rows it exposes.

Other behaviour can only be shown by the bench's scenarios, with a scoreboard comparing every readout against a reference model:
- the arithmetic values of the product matrix and the sums;
- the mirrored lower triangle;
- correct zero padding of a short last tile;
- headroom under full-scale inputs;
- the exact length of the stall after a full tile;
- that rows offered outside a run change nothing.

// File: rtl/gram_pkg.sv
package gram_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_FOLD = 2'd2
  } gram_state_e;

  // Linear slot of upper-triangle element (i,j), j >= i, row-major.
  function automatic int tri_slot(input int i, input int j, input int nf);
    return i * nf - (i * (i - 1)) / 2 + (j - i);
  endfunction

endpackage

// File: rtl/gram_tile_buf.sv
module gram_tile_buf #(
  parameter int NF = 4,
  parameter int DW = 16,
  localparam int RW = $clog2(NF)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               wr_en,
  input  logic [RW-1:0]      wr_row,
  input  logic [NF*DW-1:0]   wr_data,
  input  logic [RW-1:0]      sel_a,
  input  logic [RW-1:0]      sel_b,
  output logic [NF*DW-1:0]   col_a,
  output logic [NF*DW-1:0]   col_b
);

  logic [NF*DW-1:0] rows_q [NF];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int r = 0; r < NF; r++) rows_q[r] <= '0;
    end else if (wr_en) begin
      rows_q[wr_row] <= wr_data;
    end
  end

  // Expose two feature columns of the tile, element r = sample row r.
  for (genvar r = 0; r < NF; r++) begin : g_col
    assign col_a[r*DW +: DW] = rows_q[r][sel_a*DW +: DW];
    assign col_b[r*DW +: DW] = rows_q[r][sel_b*DW +: DW];
  end

  // R5: a cleared tile reads as zero rows, so padding adds nothing
  p_pad_zero_r5: assert property (@(posedge clk) disable iff (rst)
    clr |=> (col_a == '0 && col_b == '0));

endmodule

// File: rtl/gram_dot.sv
module gram_dot #(
  parameter int NF = 4,
  parameter int DW = 16,
  parameter int OW = 2 * DW + $clog2(NF) + 1
) (
  input  logic [NF*DW-1:0]   vec_a,
  input  logic [NF*DW-1:0]   vec_b,
  output logic signed [OW-1:0] dot
);

  logic signed [2*DW-1:0] prod [NF];

  for (genvar r = 0; r < NF; r++) begin : g_mul
    assign prod[r] = $signed(vec_a[r*DW +: DW]) * $signed(vec_b[r*DW +: DW]);
  end

  always_comb begin
    dot = '0;
    for (int r = 0; r < NF; r++) dot = dot + OW'(prod[r]);
  end

endmodule

// File: rtl/gram_tri_acc.sv
module gram_tri_acc #(
  parameter int NP   = 10,
  parameter int AW   = 45,
  parameter int DOTW = 35,
  localparam int IW  = $clog2(NP)
) (
  input  logic                   clk,
  input  logic                   add_en,
  input  logic                   add_first,
  input  logic [IW-1:0]          add_idx,
  input  logic signed [DOTW-1:0] add_val,
  input  logic [IW-1:0]          rd_idx,
  output logic [AW-1:0]          rd_val
);

  logic signed [AW-1:0] mem_q [NP];

  // The first tile overwrites, so no clear sweep is needed on start.
  always_ff @(posedge clk) begin
    if (add_en) begin
      if (add_first) mem_q[add_idx] <= AW'(add_val);
      else           mem_q[add_idx] <= mem_q[add_idx] + AW'(add_val);
    end
    rd_val <= mem_q[rd_idx];
  end

endmodule

// File: rtl/gram_accum.sv
module gram_accum
  import gram_pkg::*;
#(
  parameter int NF     = 4,
  parameter int DW     = 16,
  parameter int NS_MAX = 4096,
  localparam int RW    = $clog2(NF),
  localparam int NP    = NF * (NF + 1) / 2,
  localparam int IW    = $clog2(NP),
  localparam int DOTW  = 2 * DW + $clog2(NF) + 1,
  localparam int AW    = 2 * DW + $clog2(NS_MAX) + 1,
  localparam int SW    = DW + $clog2(NS_MAX) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [NF*DW-1:0] s_data,
  input  logic             s_last,
  output logic             done,
  input  logic [RW-1:0]    rd_row,
  input  logic [RW-1:0]    rd_col,
  output logic [AW-1:0]    rd_gram,
  output logic [SW-1:0]    rd_sum
);

  gram_state_e state_q;
  logic [RW-1:0] row_q, pi_q, pj_q;
  logic [IW-1:0] pidx_q;
  logic          last_tile_q, first_tile_q, done_q;
  logic signed [SW-1:0] sums_q [NF];
  logic [NF*SW-1:0] sums_flat;
  logic [SW-1:0]    rd_sum_q;

  logic accept, tile_end, fold_end;
  logic [NF*DW-1:0] col_a, col_b;
  logic signed [DOTW-1:0] dot;
  logic [IW-1:0] rd_idx;

  assign s_ready  = (state_q == ST_FILL);
  assign accept   = s_valid && s_ready;
  assign tile_end = accept && (row_q == RW'(NF - 1) || s_last);
  assign fold_end = (state_q == ST_FOLD) && (pidx_q == IW'(NP - 1));

  // Control: fill a tile, then walk the upper triangle one slot per cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      row_q        <= '0;
      pi_q         <= '0;
      pj_q         <= '0;
      pidx_q       <= '0;
      last_tile_q  <= 1'b0;
      first_tile_q <= 1'b0;
      done_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        state_q      <= ST_FILL;
        row_q        <= '0;
        pi_q         <= '0;
        pj_q         <= '0;
        pidx_q       <= '0;
        last_tile_q  <= 1'b0;
        first_tile_q <= 1'b1;
      end else begin
        case (state_q)
          ST_FILL: begin
            if (accept) begin
              row_q <= row_q + 1'b1;
              if (tile_end) begin
                state_q     <= ST_FOLD;
                last_tile_q <= s_last;
                pi_q        <= '0;
                pj_q        <= '0;
                pidx_q      <= '0;
              end
            end
          end
          ST_FOLD: begin
            pidx_q <= pidx_q + 1'b1;
            if (pj_q == RW'(NF - 1)) begin
              pi_q <= pi_q + 1'b1;
              pj_q <= pi_q + 1'b1;
            end else begin
              pj_q <= pj_q + 1'b1;
            end
            if (fold_end) begin
              row_q        <= '0;
              first_tile_q <= 1'b0;
              if (last_tile_q) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end else begin
                state_q <= ST_FILL;
              end
            end
          end
          default: state_q <= state_q;
        endcase
      end
    end
  end

  assign done = done_q;

  // Column sums ride along with row acceptance: no second pass.
  for (genvar f = 0; f < NF; f++) begin : g_sum
    always_ff @(posedge clk) begin
      if (rst || start) sums_q[f] <= '0;
      else if (accept)  sums_q[f] <= sums_q[f] + SW'($signed(s_data[f*DW +: DW]));
    end
    assign sums_flat[f*SW +: SW] = sums_q[f];
  end

  gram_tile_buf #(.NF(NF), .DW(DW)) tile_i (
    .clk(clk), .rst(rst), .clr(start || fold_end),
    .wr_en(accept), .wr_row(row_q), .wr_data(s_data),
    .sel_a(pi_q), .sel_b(pj_q), .col_a(col_a), .col_b(col_b)
  );

  gram_dot #(.NF(NF), .DW(DW), .OW(DOTW)) dot_i (
    .vec_a(col_a), .vec_b(col_b), .dot(dot)
  );

  // Mirror lower-triangle requests onto the stored upper triangle.
  always_comb begin
    int lo, hi;
    lo = (rd_row <= rd_col) ? int'(rd_row) : int'(rd_col);
    hi = (rd_row <= rd_col) ? int'(rd_col) : int'(rd_row);
    rd_idx = IW'(tri_slot(lo, hi, NF));
  end

  gram_tri_acc #(.NP(NP), .AW(AW), .DOTW(DOTW)) acc_i (
    .clk(clk), .add_en(state_q == ST_FOLD), .add_first(first_tile_q),
    .add_idx(pidx_q), .add_val(dot), .rd_idx(rd_idx), .rd_val(rd_gram)
  );

  always_ff @(posedge clk) rd_sum_q <= sums_q[rd_col];
  assign rd_sum = rd_sum_q;

  // R1: start reopens the input with done low
  p_start_opens_r1: assert property (@(posedge clk) disable iff (rst)
    start |=> (s_ready && !done));

  // R4: closing a tile stalls the input on the next cycle
  p_tile_stall_r4: assert property (@(posedge clk) disable iff (rst)
    (tile_end && !start) |=> !s_ready);

  // R6: done never lasts two cycles
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: no row is taken while done is reported
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !s_ready);

  // R3: sums move only on an accepted row
  p_sum_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!accept && !start) |=> $stable(sums_flat));

endmodule

// File: tb/gram_accum_tb_top.sv
module gram_accum_tb_top;

  localparam int NF = 4, DW = 16, NS_MAX = 4096;
  localparam int RW = 2, NP = NF * (NF + 1) / 2;
  localparam int AW = 2 * DW + 12 + 1, SW = DW + 12 + 1;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic s_valid = 1'b0, s_last = 1'b0, s_ready, done;
  logic [NF*DW-1:0] s_data = '0;
  logic [RW-1:0] rd_row = '0, rd_col = '0;
  logic [AW-1:0] rd_gram;
  logic [SW-1:0] rd_sum;

  gram_accum #(.NF(NF), .DW(DW), .NS_MAX(NS_MAX)) dut_i (
    .clk(clk), .rst(rst), .start(start), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .done(done), .rd_row(rd_row),
    .rd_col(rd_col), .rd_gram(rd_gram), .rd_sum(rd_sum)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int unsigned seed = 32'h1234_5678;
  longint eg [NF][NF];
  longint es [NF];

  typedef struct { longint g; longint s; int r; int c; } exp_t;
  exp_t exp_q[$];
  exp_t mon_it;
  bit issued = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic signed [DW-1:0] gen_val(input int mode, input int k, input int f);
    seed = seed * 32'd1103515245 + 32'd12345;
    case (mode)
      1:       return ((k + f) % 2 == 0) ? -16'sd32768 : 16'sd32767;
      2:       return -$signed({1'b0, seed[22:16]});
      default: return seed[30:15];
    endcase
  endfunction

  // Scoreboard monitor: one expected item per issued readout address.
  always @(posedge clk) begin
    if (issued) begin
      mon_it = exp_q.pop_front();
      #2;
      check($signed(rd_gram) == mon_it.g, (mon_it.r > mon_it.c) ? "R7" : "R2",
            $sformatf("gram(%0d,%0d)", mon_it.r, mon_it.c), $signed(rd_gram), mon_it.g);
      check($signed(rd_sum) == mon_it.s, "R3", $sformatf("sum(%0d)", mon_it.c),
            $signed(rd_sum), mon_it.s);
    end
  end

  task automatic readout();
    for (int r = 0; r < NF; r++)
      for (int c = 0; c < NF; c++) begin
        rd_row = RW'(r);
        rd_col = RW'(c);
        exp_q.push_back('{g: eg[r][c], s: es[c], r: r, c: c});
        issued = 1'b1;
        @(negedge clk);
      end
    issued = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_matrix(input int ns, input int mode, input string req);
    logic [NF*DW-1:0] row;
    logic signed [DW-1:0] v [NF];
    int n;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(s_ready && !done, "R1", "ready/done after start", {s_ready, done}, 2);
    for (int a = 0; a < NF; a++) begin
      es[a] = 0;
      for (int b = 0; b < NF; b++) eg[a][b] = 0;
    end
    for (int k = 0; k < ns; k++) begin
      for (int f = 0; f < NF; f++) begin
        v[f] = gen_val(mode, k, f);
        row[f*DW +: DW] = v[f];
      end
      for (int a = 0; a < NF; a++) begin
        es[a] += v[a];
        for (int b = 0; b < NF; b++) eg[a][b] += longint'(v[a]) * longint'(v[b]);
      end
      s_valid = 1'b1;
      s_data  = row;
      s_last  = (k == ns - 1);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
      s_valid = 1'b0;
      s_last  = 1'b0;
      n = 0;
      if (k == ns - 1) begin
        while (!done && n < 100) begin n++; @(negedge clk); end
        check(n == NP, (ns % NF != 0) ? "R5" : "R6", "cycles to done", n, NP);
        check(!s_ready, "R8", "ready while done", s_ready, 0);
        @(negedge clk);
        check(!done, "R6", "done width", done, 0);
      end else if (k % NF == NF - 1) begin
        while (!s_ready && n < 100) begin n++; @(negedge clk); end
        check(n == NP, "R4", "stall after full tile", n, NP);
      end
    end
    $display("run %s: %0d rows", req, ns);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!s_ready, "R8", "ready after reset", s_ready, 0);
    check(!done, "R8", "done after reset", done, 0);

    run_matrix(8, 0, "R2");      // two full tiles
    readout();
    // R8: rows offered after done are ignored
    for (int i = 0; i < 5; i++) begin
      s_valid = 1'b1;
      s_last  = 1'b1;
      s_data  = {NF{16'h7fff}};
      @(negedge clk);
      check(!s_ready, "R8", "ready while idle", s_ready, 0);
      check(!done, "R8", "done while idle", done, 0);
    end
    s_valid = 1'b0;
    s_last  = 1'b0;
    readout();

    run_matrix(6, 2, "R5");      // partial last tile, negative values (R1 clear)
    readout();
    run_matrix(1, 0, "R5");      // single row
    readout();
    run_matrix(23, 1, "R9");     // full-scale values beyond 32-bit sums
    readout();
    finish_run();
  end

endmodule